// File: doc/BRIEF.md
# Bit-Serial Programmable Interval Decrementer

This block is an interval timer built around a down-counter that software programs and inspects one bit at a time over a bit-addressed serial I/O port. Each access names a single bit address and either writes one data bit or reads one bit back. Address 0 holds a mode bit that chooses between clock mode and interrupt mode. In clock mode, the next addresses up form a start-value register. Writing any one of its bits reloads the whole counter at once. Reading those same addresses returns a read-back register that stays frozen while in clock mode, so software can assemble a stable multi-bit value from several single-bit reads.

A prescaler divides the input clock so that the counter steps once every `PRESCALE` clocks. In interrupt mode, every step refreshes the read-back register with the new count. An external select strobe refreshes it in either mode. When the counter reaches zero and the start value is nonzero, a sticky timer request is raised. That request drives the level-3 interrupt output in place of the external level-3 input, and it is gated by the level-3 arm input. With a start value of zero, the counter keeps running through its full range but never raises the request.

Top module: `pit_decrementer`

## Requirements
- R1: The counter is `CNT_W` bits wide (default 14). It changes by a decrement step only once every `PRESCALE` clock cycles (default 64), and each such step subtracts exactly one unless R6 applies.
- R2: A write to bit address 0 with data 1 selects clock mode; data 0 selects interrupt mode. A read of address 0 returns 1 in clock mode and 0 in interrupt mode.
- R3: In clock mode, a write to bit address k (1 ≤ k ≤ `CNT_W`) sets bit k-1 of the start value to the written data. Address 1 is the LSB.
- R4: On the same clock edge, each write of R3 copies the complete updated start value into the counter and clears the timer request.
- R5: In interrupt mode, the read-back register takes the new counter value on every decrement step. In clock mode, it keeps its value unless the select strobe is high.
- R6: At a step where the counter is zero, the counter loads the start value if that value is nonzero. If the start value is zero, the counter wraps to all ones.
- R7: The timer request `tmr_irq` rises at the step that brings the counter from 1 to 0, but only when the start value is nonzero. It never rises while the start value is zero. Once high, it stays high until an R3 write or reset.
- R8: `lvl3_req` equals `lvl3_arm` AND (`tmr_irq` when the start value is nonzero, otherwise `ext_lvl3`).
- R9: A cycle with `sel_strobe` high loads the read-back register with the value the counter holds after that same edge, in either mode.
- R10: In clock mode, a read of address k (1 ≤ k ≤ `CNT_W`) returns read-back bit k-1. In interrupt mode, those addresses read 0. Addresses above `CNT_W` always read 0.
- R11: In interrupt mode, writes to addresses 1..`CNT_W` change neither the start value, nor the counter, nor the timer request.
- R12: Synchronous reset clears the counter, start value, read-back register, prescaler and timer request, and selects interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_addr | input | ADDR_W | Bit address for the current read or write |
| bit_wr | input | 1 | Write strobe for the addressed bit |
| bit_wdata | input | 1 | Data bit to write |
| bit_rdata | output | 1 | Combinational read of the addressed bit |
| sel_strobe | input | 1 | Select strobe: copies the counter into the read-back register |
| lvl3_arm | input | 1 | Level-3 mask bit (1 = armed) |
| ext_lvl3 | input | 1 | External level-3 request, active high |
| tmr_irq | output | 1 | Sticky timer request |
| lvl3_req | output | 1 | Gated level-3 interrupt request |

## Verification
Writes, mode changes and strobes take effect at the clock edge that samples them. `bit_rdata` is combinational from the address and the registered state, so the bench drives inputs on the falling edge and compares one nanosecond later. In that window, every registered effect of the previous rising edge is visible. The latency from a start-value load to the timer request depends on the prescaler phase. For start value s, the request must appear between (s-1)·PRESCALE+1 and s·PRESCALE edges after the loading edge, and the bench sweeps every nonzero start value against that window. A cycle-accurate model built from the requirements runs beside the design and is compared on every falling edge. This pins down the exact step cycle, the reload and the read-back contents, which the windowed checks leave open.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Operating mode held in the control bit at address 0
    typedef enum logic {
        MODE_INTR  = 1'b0,
        MODE_CLOCK = 1'b1
    } mode_e;

    // Per-cycle commands handed to the counter
    typedef struct packed {
        logic load;   // bit write in clock mode: reload from start value
        logic step;   // prescaler step
    } cnt_ctl_t;

    localparam int unsigned CTRL_ADDR = 0;

    function automatic mode_e mode_from_bit(input logic b);
        return b ? MODE_CLOCK : MODE_INTR;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int unsigned PRESCALE = 64
) (
    input  logic clk,
    input  logic rst,
    output logic step
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
        end else if (ph_q == LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign step = (ph_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_gap_chk
            AST_STEP_GAP: assert property (@(posedge clk) disable iff (rst)
                step |=> !step) else $error("step on consecutive cycles"); // R1
        end
    endgenerate

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             irq_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic start_nz;
    logic irq_d;

    assign start_nz = (start_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (ctl.load) begin
            cnt_d = load_val;
        end else if (ctl.step) begin
            if (cnt_q == '0 && start_nz) begin
                cnt_d = start_q;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        irq_d = irq_q;
        if (ctl.load) begin
            irq_d = 1'b0;
        end else if (ctl.step && cnt_q == ONE && start_nz) begin
            irq_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= irq_d;
        end
    end

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> cnt_q == $past(load_val)) else $error("load missed"); // R4

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> !irq_q) else $error("request survived load"); // R4

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
        (ctl.step && !ctl.load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE)
        else $error("bad decrement"); // R1

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (cnt_q == '0 && start_q != '0))
        else $error("request without terminal count"); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ctl.load) |=> irq_q) else $error("request dropped"); // R7

endmodule

// File: rtl/pit_access.sv
module pit_access
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W  = 14,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_data,
    input  logic              strobe,
    input  logic              step,
    input  logic [CNT_W-1:0]  cnt_d,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  start_q,
    output logic [CNT_W-1:0]  rb_q,
    output logic              rd_data
);
    mode_e            mode_q;
    logic [CNT_W-1:0] sel_oh;
    logic             ctrl_hit;
    logic             start_hit;
    logic             in_clock;

    assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));
    assign in_clock = (mode_q == MODE_CLOCK);

    // One-hot select of the start/read-back bit named by the address
    always_comb begin
        for (int i = 0; i < int'(CNT_W); i++) begin
            sel_oh[i] = (addr == ADDR_W'(i + 1));
        end
    end

    assign start_hit = |sel_oh;
    assign load      = wr_en && in_clock && start_hit;
    assign load_val  = (start_q & ~sel_oh) | (sel_oh & {CNT_W{wr_data}});

    always_comb begin
        if (ctrl_hit) begin
            rd_data = in_clock;
        end else if (in_clock) begin
            rd_data = |(sel_oh & rb_q);
        end else begin
            rd_data = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_INTR;
            start_q <= '0;
            rb_q    <= '0;
        end else begin
            if (wr_en && ctrl_hit) begin
                mode_q <= mode_from_bit(wr_data);
            end
            if (load) begin
                start_q <= load_val;
            end
            if (strobe || (step && !in_clock)) begin
                rb_q <= cnt_d;
            end
        end
    end

    AST_RB_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (in_clock && !strobe) |=> $stable(rb_q)) else $error("read-back moved"); // R5

    AST_INTR_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_clock && !ctrl_hit) |=> $stable(start_q))
        else $error("start changed in interrupt mode"); // R11

endmodule

// File: rtl/pit_decrementer.sv
module pit_decrementer
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W    = 14,
    parameter int unsigned PRESCALE = 64,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_wr,
    input  logic              bit_wdata,
    output logic              bit_rdata,
    input  logic              sel_strobe,
    input  logic              lvl3_arm,
    input  logic              ext_lvl3,
    output logic              tmr_irq,
    output logic              lvl3_req
);
    logic             step;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] rb_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    cnt_ctl_t         ctl;

    assign ctl.load = load;
    assign ctl.step = step;

    pit_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .step (step)
    );

    pit_access #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_access (
        .clk      (clk),
        .rst      (rst),
        .addr     (bit_addr),
        .wr_en    (bit_wr),
        .wr_data  (bit_wdata),
        .strobe   (sel_strobe),
        .step     (step),
        .cnt_d    (cnt_d),
        .load     (load),
        .load_val (load_val),
        .start_q  (start_q),
        .rb_q     (rb_q),
        .rd_data  (bit_rdata)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (load_val),
        .start_q  (start_q),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .irq_q    (tmr_irq)
    );

    // Timer owns level 3 while a nonzero start value enables it
    assign lvl3_req = lvl3_arm && ((start_q != '0) ? tmr_irq : ext_lvl3);

    AST_STROBE_COPY: assert property (@(posedge clk) disable iff (rst)
        sel_strobe |=> rb_q == cnt_q) else $error("strobe copy wrong"); // R9

endmodule

// File: tb/tb_pit_decrementer.sv
`timescale 1ns/1ps
module tb_pit_decrementer;
    localparam int W  = 5;
    localparam int P  = 4;
    localparam int AW = 3;
    localparam int MAXV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bit_addr = '0;
    logic          bit_wr = 1'b0;
    logic          bit_wdata = 1'b0;
    logic          sel_strobe = 1'b0;
    logic          lvl3_arm = 1'b1;
    logic          ext_lvl3 = 1'b0;
    logic          bit_rdata, tmr_irq, lvl3_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit lock_en = 1'b0;

    always #4 clk = ~clk;

    pit_decrementer #(.CNT_W(W), .PRESCALE(P), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bit_addr(bit_addr), .bit_wr(bit_wr),
        .bit_wdata(bit_wdata), .bit_rdata(bit_rdata), .sel_strobe(sel_strobe),
        .lvl3_arm(lvl3_arm), .ext_lvl3(ext_lvl3), .tmr_irq(tmr_irq),
        .lvl3_req(lvl3_req)
    );

    // Reference model written from the requirements
    int         m_presc, m_cnt;
    logic [W-1:0] m_start, m_rb;
    logic       m_mode, m_irq;

    always @(posedge clk) begin
        bit step, ld;
        logic [W-1:0] ns;
        int nc;
        if (rst) begin
            m_presc <= 0; m_cnt <= 0; m_start <= '0; m_rb <= '0;
            m_mode <= 1'b0; m_irq <= 1'b0;
        end else begin
            step = (m_presc == P - 1);
            ld   = bit_wr && m_mode && bit_addr >= 1 && bit_addr <= W;
            ns   = m_start;
            if (ld) ns[bit_addr - 1] = bit_wdata;
            if (ld) nc = int'(ns);
            else if (step) nc = (m_cnt == 0 && m_start != 0) ? int'(m_start) : ((m_cnt - 1) & MAXV);
            else nc = m_cnt;
            if (ld) m_irq <= 1'b0;
            else if (step && m_cnt == 1 && m_start != 0) m_irq <= 1'b1;
            if (sel_strobe || (step && !m_mode)) m_rb <= W'(nc);
            if (bit_wr && bit_addr == 0) m_mode <= bit_wdata;
            m_start <= ns;
            m_cnt   <= nc;
            m_presc <= step ? 0 : m_presc + 1;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_rd();
        if (bit_addr == 0) return int'(m_mode);
        if (m_mode && bit_addr <= W) return int'(m_rb[bit_addr - 1]);
        return 0;
    endfunction

    // Lockstep comparison on every falling edge
    always @(negedge clk) begin
        #2;
        if (!rst && lock_en) begin
            chk("R10 read mux", int'(bit_rdata), exp_rd());
            chk("R7 timer request", int'(tmr_irq), int'(m_irq));
            chk("R8 level-3 output", int'(lvl3_req),
                int'(lvl3_arm && ((m_start != 0) ? m_irq : ext_lvl3)));
        end
    end

    task automatic wr(input int a, input bit d, input bit stb);
        @(negedge clk);
        bit_addr = AW'(a); bit_wdata = d; bit_wr = 1'b1; sel_strobe = stb;
        @(negedge clk);
        bit_wr = 1'b0; bit_wdata = 1'b0; sel_strobe = 1'b0;
    endtask

    task automatic load_start(input int v, input bit stb_last);
        for (int b = 1; b <= W; b++) wr(b, v[b-1], stb_last && (b == W));
    endtask

    // Assemble the read-back value one bit per cycle (clock mode only)
    task automatic read_rb(output int v);
        v = 0;
        for (int a = 1; a <= W; a++) begin
            bit_addr = AW'(a);
            #1;
            v = v | (int'(bit_rdata) << (a - 1));
            @(negedge clk);
        end
    endtask

    task automatic strobe_once();
        @(negedge clk); sel_strobe = 1'b1;
        @(negedge clk); sel_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        int v, cap, n;
        bit seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        lock_en = 1'b1;
        #1;
        chk("R12 mode after reset", int'(bit_rdata), 0);
        chk("R12 request after reset", int'(tmr_irq), 0);
        chk("R12 level-3 after reset", int'(lvl3_req), 0);

        wr(0, 1'b1, 1'b0);
        bit_addr = '0; #1;
        chk("R2 clock mode reads 1", int'(bit_rdata), 1);
        read_rb(v);
        chk("R12 read-back tracks model", v, int'(m_rb));

        // R3/R4: load 3 with a strobe on the last bit write
        load_start(3, 1'b1);
        chk("R4 request cleared by load", int'(tmr_irq), 0);
        read_rb(v);
        chk("R3 R4 counter loaded with start", v, 3);

        // R7: latency and stickiness
        n = 0;
        while (!tmr_irq && n < 200) begin @(negedge clk); #1; n++; end
        chk("R7 request raised within window", int'(n >= 1 && n <= 3 * P), 1);
        repeat (40) @(negedge clk);
        #1 chk("R7 request sticky", int'(tmr_irq), 1);

        // R8: arm and external input
        lvl3_arm = 1'b0; #1 chk("R8 disarmed", int'(lvl3_req), 0);
        lvl3_arm = 1'b1; ext_lvl3 = 1'b1;
        #1 chk("R8 timer overrides external", int'(lvl3_req), 1);
        ext_lvl3 = 1'b0;

        // R11/R10: interrupt mode writes and reads
        wr(0, 1'b0, 1'b0);
        bit_addr = '0; #1 chk("R2 interrupt mode reads 0", int'(bit_rdata), 0);
        for (int b = 1; b <= W; b++) wr(b, 1'b1, 1'b0);
        #1 chk("R11 request untouched", int'(tmr_irq), 1);
        for (int a = 1; a < (1 << AW); a++) begin
            bit_addr = AW'(a); #1;
            chk("R10 interrupt mode bit reads 0", int'(bit_rdata), 0);
            @(negedge clk);
        end
        repeat (23) @(negedge clk);
        wr(0, 1'b1, 1'b0);
        read_rb(v);
        chk("R5 read-back tracked counter", v, int'(m_rb));
        chk("R11 counter within start range", int'(v <= 3), 1);
        for (int a = W + 1; a < (1 << AW); a++) begin
            bit_addr = AW'(a); #1;
            chk("R10 unused address reads 0", int'(bit_rdata), 0);
            @(negedge clk);
        end

        // R5: frozen in clock mode
        read_rb(cap);
        repeat (37) @(negedge clk);
        read_rb(v);
        chk("R5 read-back frozen", v, cap);

        // R9: strobe in clock mode
        strobe_once();
        read_rb(v);
        chk("R9 strobe refreshed read-back", v, int'(m_rb));

        // R6: reload bound with start 2
        load_start(2, 1'b0);
        repeat (5 * P) @(negedge clk);
        strobe_once();
        read_rb(v);
        chk("R6 reload keeps counter <= start", int'(v <= 2), 1);

        // R6/R7: zero start wraps and never requests
        load_start(0, 1'b0);
        #1 chk("R4 request cleared", int'(tmr_irq), 0);
        repeat (P) @(negedge clk);
        strobe_once();
        read_rb(v);
        chk("R6 wrap to all ones", int'(v == MAXV || v == MAXV - 1), 1);
        seen = 1'b0;
        for (int c = 0; c < (MAXV + 3) * P; c++) begin
            @(negedge clk); #1;
            if (tmr_irq) seen = 1'b1;
        end
        chk("R7 zero start never requests", int'(seen), 0);

        // R1/R7: sweep every nonzero start value
        for (int s = 1; s <= MAXV; s++) begin
            load_start(s, 1'b0);
            n = 0;
            #1;
            while (!tmr_irq && n < (MAXV + 2) * P) begin @(negedge clk); #1; n++; end
            chk("R1 R7 latency lower bound", int'(n >= (s - 1) * P + 1), 1);
            chk("R1 R7 latency upper bound", int'(n <= s * P), 1);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule